// File: doc/BRIEF.md
# Zoned Secure-Memory Command Sequencer

This block sits behind a bit-level two-wire bus interface. It turns the framing strobes and whole bytes from that interface into accesses to a zoned byte memory. The memory has eight user zones of 256 bytes and one 128-byte configuration zone. A zone-select command picks the current user zone. An address byte then opens a read burst or a page write. Reads run through the whole zone and wrap within it. Writes advance only inside a 16-byte page.

Any command that changes nonvolatile state starts a self-timed write cycle at the stop strobe. During that cycle every command byte gets a negative acknowledge, so the host can poll until the device answers again. The cycle length is a counter parameter. Access-rights decisions and the password and authentication checks are made outside this block. They arrive as two permit inputs, which qualify the location currently on `addr_o`.

Top module: `smem_cmd_seq`

## Requirements
- R1: After a start strobe, a command byte whose value is 0xB0 through 0xB7 is acknowledged. Any other value is refused, and every following byte is also refused until the next start.
- R2: Command 0xB2 takes one argument byte. Bits 2:0 of that byte become the user-zone number, which forms address bits 10:8, and bits 7:3 are ignored. The zone holds until the next 0xB2.
- R3: Until the first 0xB2 has been received after reset, every user-zone read byte (command 0xB1) returns 0x00.
- R4: During a read (0xB1 user, 0xB5 configuration), the byte address advances after each host acknowledge. It wraps from 0xFF to 0x00 in a user zone and from 0x7F to 0x00 in the configuration zone.
- R5: A host negative acknowledge after a read byte ends the read, and no further read byte is presented.
- R6: A read byte whose location has `rd_permit_i` low is returned as 0x00.
- R7: During a write (0xB0 user, 0xB4 configuration), each data byte goes to the current address, and only address bits 3:0 then advance. A write that passes the end of a 16-byte page wraps to the start of that page.
- R8: A data byte whose location has `wr_permit_i` low leaves the memory unchanged, is still acknowledged, and does not stop the write cycle from starting.
- R9: A stop strobe after an accepted 0xB0, 0xB3, 0xB4, 0xB6 or 0xB7 starts a write cycle of `WR_CYCLES` clocks. During that cycle command bytes are refused; once it ends they are accepted again. A stop strobe after 0xB1, 0xB2 or 0xB5 starts no cycle.
- R10: Argument bytes of 0xB3, 0xB6 and 0xB7 are all acknowledged.
- R11: `ack_vld_o` pulses in the clock after each received byte. A read byte appears on `tx_vld_o` two clocks after its address byte or after the host acknowledge of the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition strobe |
| stop_i | input | 1 | Stop condition strobe |
| rx_vld_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| host_ack_vld_i | input | 1 | Host acknowledge slot after a read byte |
| host_ack_i | input | 1 | 1 = host acknowledged, 0 = host did not |
| rd_permit_i | input | 1 | Read allowed at `addr_o` |
| wr_permit_i | input | 1 | Write allowed at `addr_o` |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = device acknowledges the byte |
| tx_vld_o | output | 1 | Read byte valid |
| tx_byte_o | output | 8 | Read byte |
| addr_o | output | 11 | Current address {zone, byte} |
| cfg_sel_o | output | 1 | Current access targets the configuration zone |

## Verification
Most internal faults in this block show up at the ports within one transaction. A wrong state or a wrong decoded command makes `ack_o` wrong in the clock after the offending byte. A wrong address counter shows up as a wrong value on `tx_byte_o` when the data is read back, at the wrap byte itself. A zone register that moves, or a page counter that carries into the upper bits, corrupts a byte in another zone or page, and a later read-back of that byte exposes it. A write-cycle counter that is too short or too long is caught by a command byte sent right after stop and by another sent after the cycle should have ended.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [7:0] {
    CMD_WR_USER   = 8'hB0,
    CMD_RD_USER   = 8'hB1,
    CMD_SET_ZONE  = 8'hB2,
    CMD_CHK_PW    = 8'hB3,
    CMD_WR_CFG    = 8'hB4,
    CMD_RD_CFG    = 8'hB5,
    CMD_AUTH_INIT = 8'hB6,
    CMD_AUTH_CHK  = 8'hB7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_ZONE, ST_RD_FETCH, ST_RD_WAIT, ST_WR, ST_ARG
  } state_e;
endpackage

// File: rtl/smem_wr_timer.sv
module smem_wr_timer #(
  parameter int WR_CYCLES = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (load_i)      cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);

  AST_BUSY_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt == $past(cnt) - CW'(1))); // R9
  AST_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o); // R9
endmodule

// File: rtl/smem_addr_ctr.sv
module smem_addr_ctr #(
  parameter int ZONE_AW = 8,
  parameter int ZSEL_W  = 3,
  parameter int CFG_AW  = 7,
  parameter int PAGE_AW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               zone_ld_i,
  input  logic [ZSEL_W-1:0]  zone_d_i,
  input  logic               addr_ld_i,
  input  logic [ZONE_AW-1:0] addr_d_i,
  input  logic               cfg_i,
  input  logic               rd_inc_i,
  input  logic               wr_inc_i,
  output logic [ZSEL_W-1:0]  zone_o,
  output logic [ZONE_AW-1:0] lo_o,
  output logic               zone_vld_o
);
  localparam logic [ZONE_AW-1:0] CFG_MASK = ZONE_AW'((1 << CFG_AW) - 1);

  logic [ZONE_AW-1:0] rd_mask;
  assign rd_mask = cfg_i ? CFG_MASK : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zone_o     <= '0;
      zone_vld_o <= 1'b0;
    end else if (zone_ld_i) begin
      zone_o     <= zone_d_i;
      zone_vld_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lo_o <= '0;
    else if (addr_ld_i) lo_o <= addr_d_i & rd_mask;
    else if (rd_inc_i)  lo_o <= (lo_o + ZONE_AW'(1)) & rd_mask;
    else if (wr_inc_i)  lo_o <= {lo_o[ZONE_AW-1:PAGE_AW], lo_o[PAGE_AW-1:0] + PAGE_AW'(1)};
  end

  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_inc_i && !addr_ld_i && !rd_inc_i) |=>
      (lo_o[ZONE_AW-1:PAGE_AW] == $past(lo_o[ZONE_AW-1:PAGE_AW]))); // R7
  AST_RD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_inc_i && !addr_ld_i && !cfg_i && (&lo_o)) |=> (lo_o == '0)); // R4
  AST_ZONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zone_ld_i |=> $stable(zone_o)); // R2
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int ZONE_AW = 8,
  parameter int ZSEL_W  = 3,
  parameter int CFG_AW  = 7
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic               cfg_i,
  input  logic [ZSEL_W-1:0]  zone_i,
  input  logic [ZONE_AW-1:0] lo_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o
);
  localparam int USER_BYTES = 1 << (ZONE_AW + ZSEL_W);
  localparam int CFG_BYTES  = 1 << CFG_AW;

  logic [7:0] user_mem [USER_BYTES];
  logic [7:0] cfg_mem  [CFG_BYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (cfg_i) cfg_mem[lo_i[CFG_AW-1:0]] <= wdata_i;
      else       user_mem[{zone_i, lo_i}] <= wdata_i;
    end
  end

  assign rdata_o = cfg_i ? cfg_mem[lo_i[CFG_AW-1:0]] : user_mem[{zone_i, lo_i}];
endmodule

// File: rtl/smem_cmd_seq.sv
module smem_cmd_seq
  import smem_pkg::*;
#(
  parameter int ZONE_CNT   = 8,
  parameter int ZONE_BYTES = 256,
  parameter int CFG_BYTES  = 128,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 2_000_000,
  localparam int ZSEL_W  = $clog2(ZONE_CNT),
  localparam int ZONE_AW = $clog2(ZONE_BYTES),
  localparam int AW      = ZSEL_W + ZONE_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rx_vld_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          host_ack_vld_i,
  input  logic          host_ack_i,
  input  logic          rd_permit_i,
  input  logic          wr_permit_i,
  output logic          ack_vld_o,
  output logic          ack_o,
  output logic          tx_vld_o,
  output logic [7:0]    tx_byte_o,
  output logic [AW-1:0] addr_o,
  output logic          cfg_sel_o
);
  localparam int CFG_AW  = $clog2(CFG_BYTES);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);

  state_e             state;
  logic               cur_cfg, cur_rd, wr_pend;
  logic               busy, byte_ok;
  logic               zone_ld, addr_ld, wr_inc, rd_inc, mem_we, tmr_load;
  logic               permit_rd, permit_wr, zone_vld;
  logic [ZSEL_W-1:0]  zone;
  logic [ZONE_AW-1:0] lo;
  logic [7:0]         mem_rdata;

  // framing strobes win over a byte in the same clock
  assign byte_ok   = rx_vld_i && !start_i && !stop_i;
  assign zone_ld   = byte_ok && (state == ST_ZONE);
  assign addr_ld   = byte_ok && (state == ST_ADDR);
  assign wr_inc    = byte_ok && (state == ST_WR);
  assign rd_inc    = !start_i && !stop_i && host_ack_vld_i && host_ack_i && (state == ST_RD_WAIT);
  assign permit_rd = rd_permit_i && (cur_cfg || zone_vld);
  assign permit_wr = wr_permit_i && (cur_cfg || zone_vld);
  assign mem_we    = wr_inc && permit_wr;
  assign tmr_load  = stop_i && !start_i && wr_pend;

  smem_wr_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .busy_o(busy)
  );

  smem_addr_ctr #(.ZONE_AW(ZONE_AW), .ZSEL_W(ZSEL_W), .CFG_AW(CFG_AW), .PAGE_AW(PAGE_AW)) i_addr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .zone_ld_i(zone_ld), .zone_d_i(rx_byte_i[ZSEL_W-1:0]),
    .addr_ld_i(addr_ld), .addr_d_i(ZONE_AW'(rx_byte_i)),
    .cfg_i(cur_cfg), .rd_inc_i(rd_inc), .wr_inc_i(wr_inc),
    .zone_o(zone), .lo_o(lo), .zone_vld_o(zone_vld)
  );

  smem_array #(.ZONE_AW(ZONE_AW), .ZSEL_W(ZSEL_W), .CFG_AW(CFG_AW)) i_mem (
    .clk_i(clk_i), .we_i(mem_we), .cfg_i(cur_cfg), .zone_i(zone), .lo_i(lo),
    .wdata_i(rx_byte_i), .rdata_o(mem_rdata)
  );

  assign addr_o    = {zone, lo};
  assign cfg_sel_o = cur_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      cur_cfg   <= 1'b0;
      cur_rd    <= 1'b0;
      wr_pend   <= 1'b0;
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
      tx_vld_o  <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      ack_vld_o <= byte_ok;
      ack_o     <= 1'b0;
      tx_vld_o  <= 1'b0;
      if (start_i) begin
        state   <= ST_CMD;
        wr_pend <= 1'b0;
      end else if (stop_i) begin
        state   <= ST_IDLE;
        wr_pend <= 1'b0;
      end else begin
        unique case (state)
          ST_CMD: if (byte_ok) begin
            state <= ST_IDLE;
            if (!busy) begin
              case (rx_byte_i)
                CMD_WR_USER, CMD_WR_CFG: begin
                  ack_o <= 1'b1; wr_pend <= 1'b1; cur_rd <= 1'b0;
                  cur_cfg <= rx_byte_i[2]; state <= ST_ADDR;
                end
                CMD_RD_USER, CMD_RD_CFG: begin
                  ack_o <= 1'b1; cur_rd <= 1'b1;
                  cur_cfg <= rx_byte_i[2]; state <= ST_ADDR;
                end
                CMD_SET_ZONE: begin
                  ack_o <= 1'b1; state <= ST_ZONE;
                end
                CMD_CHK_PW, CMD_AUTH_INIT, CMD_AUTH_CHK: begin
                  ack_o <= 1'b1; wr_pend <= 1'b1; state <= ST_ARG;
                end
                default: state <= ST_IDLE;
              endcase
            end
          end
          ST_ZONE: if (byte_ok) begin
            ack_o <= 1'b1;
            state <= ST_IDLE;
          end
          ST_ADDR: if (byte_ok) begin
            ack_o <= 1'b1;
            state <= cur_rd ? ST_RD_FETCH : ST_WR;
          end
          ST_WR:  if (byte_ok) ack_o <= 1'b1;
          ST_ARG: if (byte_ok) ack_o <= 1'b1;
          ST_RD_FETCH: begin
            tx_vld_o  <= 1'b1;
            tx_byte_o <= permit_rd ? mem_rdata : 8'h00;
            state     <= ST_RD_WAIT;
          end
          ST_RD_WAIT: if (host_ack_vld_i) state <= host_ack_i ? ST_RD_FETCH : ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ok && state == ST_CMD && busy) |=> (ack_vld_o && !ack_o)); // R9
  AST_NOZONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_vld_o && !cur_cfg && !zone_vld) |-> (tx_byte_o == 8'h00)); // R3
  AST_NACK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD_WAIT && host_ack_vld_i && !host_ack_i && !start_i) |=> ##1 !tx_vld_o); // R5
  AST_ACK_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ok |=> ack_vld_o); // R11
endmodule

// File: tb/test_smem_cmd_seq.sv
`timescale 1ns/1ps
module test_smem_cmd_seq;
  localparam int WR = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 0, stop = 0, rx_vld = 0, hav = 0, ha = 0;
  logic       rd_perm = 1, wr_perm = 1;
  logic [7:0] rx_byte = '0;
  logic       ack_vld, ack, tx_vld, cfg_sel;
  logic [7:0] tx_byte;
  logic [10:0] addr;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smem_cmd_seq #(.WR_CYCLES(WR)) i_smem_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .rx_vld_i(rx_vld), .rx_byte_i(rx_byte), .host_ack_vld_i(hav), .host_ack_i(ha),
    .rd_permit_i(rd_perm), .wr_permit_i(wr_perm), .ack_vld_o(ack_vld), .ack_o(ack),
    .tx_vld_o(tx_vld), .tx_byte_o(tx_byte), .addr_o(addr), .cfg_sel_o(cfg_sel)
  );

  // {cfg, zone, addr, data}
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 3'd0, 8'h00, 8'hA5}, {1'b0, 3'd4, 8'h00, 8'h11},
    {1'b0, 3'd3, 8'h40, 8'h3C}, {1'b0, 3'd7, 8'hF8, 8'h5A},
    {1'b1, 3'd0, 8'h10, 8'hC3}, {1'b0, 3'd5, 8'h81, 8'hFF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic v, output logic a);
    @(negedge clk); rx_vld = 1; rx_byte = b;
    @(negedge clk); rx_vld = 0; v = ack_vld; a = ack;
  endtask

  task automatic send_ok(input logic [7:0] b, input string req);
    logic v, a;
    put_byte(b, v, a);
    check(v && a, req, {v, a}, 2'b11);
  endtask

  task automatic get_byte(input logic [7:0] exp, input string req);
    @(negedge clk);
    check(tx_vld === 1'b1, {req, " R11 tx latency"}, tx_vld, 1);
    check(tx_byte === exp, req, tx_byte, exp);
  endtask

  task automatic host_resp(input logic a);
    @(negedge clk); hav = 1; ha = a; @(negedge clk); hav = 0;
  endtask

  task automatic wait_cycle();
    repeat (WR + 4) @(negedge clk);
  endtask

  task automatic set_zone(input logic [7:0] zb);
    pulse_start(); send_ok(8'hB2, "R1 B2"); send_ok(zb, "R2 zone arg"); pulse_stop();
  endtask

  task automatic wr_one(input logic [7:0] cmd, input logic [7:0] a, input logic [7:0] d, input string req);
    pulse_start(); send_ok(cmd, req); send_ok(a, req); send_ok(d, req); pulse_stop(); wait_cycle();
  endtask

  task automatic rd_one(input logic [7:0] cmd, input logic [7:0] a, input logic [7:0] exp, input string req);
    pulse_start(); send_ok(cmd, req); send_ok(a, req);
    get_byte(exp, req); host_resp(1'b0); pulse_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic v, a;
    repeat (3) @(negedge clk);
    check(ack_vld == 0 && tx_vld == 0, "reset outputs", {ack_vld, tx_vld}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: no zone selected yet -> user read returns 0x00
    wr_perm = 1; rd_perm = 1;
    rd_one(8'hB1, 8'h05, 8'h00, "R3 read before zone set");

    // R1: unknown command refused, following byte refused too
    pulse_start(); put_byte(8'hA0, v, a);
    check(v && !a, "R1 unknown cmd nack", {v, a}, 2'b10);
    put_byte(8'hB1, v, a);
    check(v && !a, "R1 byte after refusal", {v, a}, 2'b10);
    pulse_stop();

    // vector table: zone (upper bits don't care), write, read back
    foreach (VEC[i]) begin
      logic [19:0] e = VEC[i];
      if (!e[19]) set_zone({5'b10101, e[18:16]});
      wr_one(e[19] ? 8'hB4 : 8'hB0, e[15:8], e[7:0], "R7 vec write");
      rd_one(e[19] ? 8'hB5 : 8'hB1, e[15:8], e[7:0], "R2 vec readback");
    end
    set_zone(8'hF8);
    rd_one(8'hB1, 8'h00, 8'hA5, "R2 zone 0 kept apart from zone 4");

    // R7: page wrap 1E,1F -> 10; 20 untouched
    set_zone(8'h01);
    wr_one(8'hB0, 8'h20, 8'hEE, "R7 prep");
    pulse_start(); send_ok(8'hB0, "R7"); send_ok(8'h1E, "R7");
    send_ok(8'h11, "R7"); send_ok(8'h22, "R7"); send_ok(8'h33, "R7");
    pulse_stop(); wait_cycle();
    rd_one(8'hB1, 8'h10, 8'h33, "R7 wrapped byte");
    rd_one(8'hB1, 8'h1F, 8'h22, "R7 second byte");
    rd_one(8'hB1, 8'h20, 8'hEE, "R7 next page untouched");

    // R4/R5: zone read wrap FF->00, then nack ends read
    set_zone(8'h02);
    wr_one(8'hB0, 8'hFF, 8'h77, "R4 prep");
    wr_one(8'hB0, 8'h00, 8'h88, "R4 prep");
    pulse_start(); send_ok(8'hB1, "R4"); send_ok(8'hFF, "R4");
    get_byte(8'h77, "R4 last byte"); host_resp(1'b1);
    get_byte(8'h88, "R4 wrap to zone start"); host_resp(1'b0);
    @(negedge clk); check(tx_vld == 0, "R5 no byte after nack", tx_vld, 0);
    @(negedge clk); check(tx_vld == 0, "R5 no byte after nack", tx_vld, 0);
    pulse_stop();

    // R4: config wrap 7F->00
    wr_one(8'hB4, 8'h7F, 8'h99, "R4 cfg prep");
    wr_one(8'hB4, 8'h00, 8'h44, "R4 cfg prep");
    pulse_start(); send_ok(8'hB5, "R4"); send_ok(8'h7F, "R4");
    get_byte(8'h99, "R4 cfg last"); host_resp(1'b1);
    get_byte(8'h44, "R4 cfg wrap"); host_resp(1'b0); pulse_stop();

    // R6: read not permitted -> 0x00
    rd_perm = 0;
    rd_one(8'hB1, 8'hFF, 8'h00, "R6 denied read");
    rd_perm = 1;

    // R8: denied write acked, cycle starts, data kept
    wr_perm = 0;
    pulse_start(); send_ok(8'hB0, "R8"); send_ok(8'h00, "R8"); send_ok(8'h12, "R8 data ack");
    pulse_stop(); wr_perm = 1;
    pulse_start(); put_byte(8'hB1, v, a);
    check(v && !a, "R8 cycle still started", {v, a}, 2'b10);
    pulse_stop(); wait_cycle();
    rd_one(8'hB1, 8'h00, 8'h88, "R8 data unchanged");

    // R9: poll during cycle, accept after; reads start no cycle
    pulse_start(); send_ok(8'hB0, "R9"); send_ok(8'h30, "R9"); send_ok(8'h5C, "R9");
    pulse_stop();
    pulse_start(); put_byte(8'hB5, v, a);
    check(v && !a, "R9 busy nack", {v, a}, 2'b10);
    pulse_stop(); wait_cycle();
    pulse_start(); put_byte(8'hB5, v, a);
    check(v && a, "R9 ack after cycle", {v, a}, 2'b11);
    pulse_stop();
    pulse_start(); put_byte(8'hB1, v, a);
    check(v && a, "R9 read stop starts no cycle", {v, a}, 2'b11);
    pulse_stop();

    // R10: auth argument bytes acked, stop starts cycle
    pulse_start(); send_ok(8'hB6, "R10 cmd");
    for (int k = 0; k < 8; k++) send_ok(8'(k * 37), "R10 arg");
    pulse_stop();
    pulse_start(); put_byte(8'hB1, v, a);
    check(v && !a, "R9 auth stop starts cycle", {v, a}, 2'b10);
    pulse_stop(); wait_cycle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule